// File: doc/BRIEF.md
# Eight-Bit Dual-Compare Timer

This block is an 8-bit up-counter paired with two compare registers (A and B) that steer a single timer output pin. A register port gives software access to the counter, both compare values and one control/status register. That register carries two 2-bit pin-action fields, one per compare channel, and three sticky event flags: match on A, match on B and counter rollover.

The flags follow a read-then-clear handshake. A status read that returns a flag as 1 arms that flag. The next write to the status register clears each armed flag whose written bit is 0. The counter advances only while the count-enable input is high. Compare events are taken only in counting cycles, so a stalled counter does not fire the same match again and again. The output pin starts low after reset. It is forced low whenever both action fields select "keep".

Top module: `tmr8_dual`

## Requirements
- R1: In each clock cycle with `cnt_en` high, the counter increases by 1 (modulo 256). With `cnt_en` low it holds. A write to address 0 loads the written value instead.
- R2: Register addresses are: 0 counter, 1 compare A, 2 compare B, 3 status. A read returns the register in the same cycle. The status layout is bit 7 match-B flag, bit 6 match-A flag, bit 5 rollover flag, bit 4 reads 0, bits 3:2 action B, bits 1:0 action A.
- R3: The rollover flag sets at the clock edge where the counter wraps from 0xFF to 0x00.
- R4: The match-A flag sets at the edge that ends a counting cycle in which the counter equals compare A.
- R5: The match-B flag sets at the edge that ends a counting cycle in which the counter equals compare B.
- R6: On a match-A event, action A sets the pin as follows: 00 keeps it, 01 drives 0, 10 drives 1, 11 inverts it. The new level appears after that edge.
- R7: Action B uses the same encodings on match-B events. When both events coincide and either selected action is 11, the pin inverts exactly once. Otherwise a non-keep B action overrides A.
- R8: The pin reads 0 while all four action bits are 0, without losing its held level. After reset it is 0 until a compare event drives it.
- R9: A flag clears only when a status write carries 0 in its bit after a status read returned it as 1. A write of 0 without that prior read leaves it set. Writing 1 never sets a flag.
- R10: When a flag's set event and its clearing write fall on the same edge, the flag stays 1.
- R11: After reset, every register reads 0 and the pin is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cnt_en | input | 1 | Count enable |
| reg_addr | input | 2 | Register address |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe (arms flags on status reads) |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, combinational from address |
| tmr_out | output | 1 | Timer output pin |

## Verification
Read data is combinational, so a read result is due in the same cycle as its strobe. The bench latches it on that cycle's closing edge and compares it at the following falling edge. Count, flag and pin effects of a counting cycle land on the edge that ends it. Each probe is therefore issued only after the stimulus cycle has closed, and with `cnt_en` low, so that no further events can occur. The pin gating by the all-zero action fields is combinational and is probed in the cycle after the control write settles.

// File: rtl/tmr8_pkg.sv
package tmr8_pkg;

  typedef enum logic [1:0] {
    ACT_KEEP = 2'b00,
    ACT_LOW  = 2'b01,
    ACT_HIGH = 2'b10,
    ACT_FLIP = 2'b11
  } pin_act_e;

  localparam int unsigned ADR_W   = 2;
  localparam logic [1:0]  ADR_CNT = 2'd0;
  localparam logic [1:0]  ADR_CMA = 2'd1;
  localparam logic [1:0]  ADR_CMB = 2'd2;
  localparam logic [1:0]  ADR_CSR = 2'd3;

  localparam int unsigned NFLAG   = 3;
  localparam int unsigned FLG_OVF = 0;
  localparam int unsigned FLG_CMA = 1;
  localparam int unsigned FLG_CMB = 2;

endpackage

// File: rtl/tmr8_counter.sv
module tmr8_counter #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cnt_en,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic [W-1:0] cnt,
  output logic         ovf_ev
);

  localparam logic [W-1:0] CNT_MAX = {W{1'b1}};

  logic [W-1:0] cnt_n;

  always_comb begin
    ovf_ev = 1'b0;
    cnt_n  = cnt;
    if (load) begin
      cnt_n = load_val;
    end else if (cnt_en) begin
      cnt_n  = cnt + {{(W-1){1'b0}}, 1'b1};
      ovf_ev = (cnt == CNT_MAX);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= cnt_n;
  end

  // R1: counting advances by one
  a_r1_count_step: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_en && !load) |=> (cnt == W'($past(cnt) + 1'b1)));

  // R1: holds when idle
  a_r1_count_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!cnt_en && !load) |=> $stable(cnt));

  // R3: rollover lands on zero
  a_r3_wrap_zero: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_ev |=> (cnt == '0));

endmodule

// File: rtl/tmr8_pin_ctl.sv
module tmr8_pin_ctl
  import tmr8_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     hit_a,
  input  logic     hit_b,
  input  pin_act_e act_a,
  input  pin_act_e act_b,
  output logic     pin
);

  logic out_q;
  logic out_n;
  logic flip;
  logic gated_off;

  always_comb begin
    flip  = (hit_a && act_a == ACT_FLIP) || (hit_b && act_b == ACT_FLIP);
    out_n = out_q;
    if (flip) begin
      out_n = ~out_q;
    end else if (hit_b && act_b != ACT_KEEP) begin
      out_n = (act_b == ACT_HIGH);
    end else if (hit_a && act_a != ACT_KEEP) begin
      out_n = (act_a == ACT_HIGH);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) out_q <= 1'b0;
    else        out_q <= out_n;
  end

  assign gated_off = (act_a == ACT_KEEP) && (act_b == ACT_KEEP);
  assign pin       = gated_off ? 1'b0 : out_q;

  // R7: an inverting event flips the level exactly once
  a_r7_flip_once: assert property (@(posedge clk) disable iff (!rst_n)
    ((hit_a && act_a == ACT_FLIP) || (hit_b && act_b == ACT_FLIP))
      |=> (out_q != $past(out_q)));

  // R8: without events the held level is kept
  a_r8_hold_level: assert property (@(posedge clk) disable iff (!rst_n)
    (!hit_a && !hit_b) |=> $stable(out_q));

  // R6: drive-high action on a lone A event
  a_r6_a_high: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_a && !hit_b && act_a == ACT_HIGH) |=> out_q);

endmodule

// File: rtl/tmr8_flags.sv
module tmr8_flags #(
  parameter int unsigned N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_ev,
  input  logic         rd_csr,
  input  logic         wr_csr,
  input  logic [N-1:0] wr_bits,
  output logic [N-1:0] flags
);

  logic [N-1:0] armed;
  logic [N-1:0] armed_n;
  logic [N-1:0] clr;
  logic [N-1:0] flags_n;

  always_comb begin
    armed_n = wr_csr ? '0 : armed;
    if (rd_csr) armed_n = armed_n | flags;
    clr     = wr_csr ? (armed & ~wr_bits) : '0;
    flags_n = (flags & ~clr) | set_ev;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags <= '0;
      armed <= '0;
    end else begin
      flags <= flags_n;
      armed <= armed_n;
    end
  end

  for (genvar i = 0; i < N; i++) begin : g_chk
    // R10: set event dominates a clearing write
    a_r10_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
      set_ev[i] |=> flags[i]);

    // R9: no clearing without a write while armed
    a_r9_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (flags[i] && !wr_csr) |=> flags[i]);

    // R9: writes never raise a flag
    a_r9_no_sw_set: assert property (@(posedge clk) disable iff (!rst_n)
      (!flags[i] && !set_ev[i]) |=> !flags[i]);
  end

endmodule

// File: rtl/tmr8_dual.sv
module tmr8_dual
  import tmr8_pkg::*;
#(
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cnt_en,
  input  logic [1:0]    reg_addr,
  input  logic          reg_wr,
  input  logic          reg_rd,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  output logic          tmr_out
);

  localparam int unsigned ACT_W = 2;
  localparam int unsigned PAD_W = DW - NFLAG - 2*ACT_W;

  // reset: asynchronous assert, synchronous release
  logic [1:0] rst_sync;
  logic       rst_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_i = rst_sync[1];

  logic [DW-1:0]      cmp_a_q, cmp_a_n;
  logic [DW-1:0]      cmp_b_q, cmp_b_n;
  logic [2*ACT_W-1:0] act_q,   act_n;
  logic [DW-1:0]      cnt;
  logic               ovf_ev;
  logic               hit_a, hit_b;
  logic [NFLAG-1:0]   flags;
  logic [NFLAG-1:0]   set_ev;
  logic               wr_cnt, wr_cma, wr_cmb, wr_csr, rd_csr;

  always_comb begin
    wr_cnt = reg_wr && (reg_addr == ADR_CNT);
    wr_cma = reg_wr && (reg_addr == ADR_CMA);
    wr_cmb = reg_wr && (reg_addr == ADR_CMB);
    wr_csr = reg_wr && (reg_addr == ADR_CSR);
    rd_csr = reg_rd && (reg_addr == ADR_CSR);
  end

  always_comb begin
    cmp_a_n = cmp_a_q;
    cmp_b_n = cmp_b_q;
    act_n   = act_q;
    if (wr_cma) cmp_a_n = reg_wdata;
    if (wr_cmb) cmp_b_n = reg_wdata;
    if (wr_csr) act_n   = reg_wdata[2*ACT_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      cmp_a_q <= '0;
      cmp_b_q <= '0;
      act_q   <= '0;
    end else begin
      cmp_a_q <= cmp_a_n;
      cmp_b_q <= cmp_b_n;
      act_q   <= act_n;
    end
  end

  tmr8_counter #(.W(DW)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_i),
    .cnt_en   (cnt_en),
    .load     (wr_cnt),
    .load_val (reg_wdata),
    .cnt      (cnt),
    .ovf_ev   (ovf_ev)
  );

  assign hit_a = cnt_en && (cnt == cmp_a_q);
  assign hit_b = cnt_en && (cnt == cmp_b_q);

  always_comb begin
    set_ev          = '0;
    set_ev[FLG_OVF] = ovf_ev;
    set_ev[FLG_CMA] = hit_a;
    set_ev[FLG_CMB] = hit_b;
  end

  tmr8_flags #(.N(NFLAG)) u_flg (
    .clk     (clk),
    .rst_n   (rst_i),
    .set_ev  (set_ev),
    .rd_csr  (rd_csr),
    .wr_csr  (wr_csr),
    .wr_bits (reg_wdata[DW-1 -: NFLAG]),
    .flags   (flags)
  );

  tmr8_pin_ctl u_pin (
    .clk   (clk),
    .rst_n (rst_i),
    .hit_a (hit_a),
    .hit_b (hit_b),
    .act_a (pin_act_e'(act_q[ACT_W-1:0])),
    .act_b (pin_act_e'(act_q[2*ACT_W-1:ACT_W])),
    .pin   (tmr_out)
  );

  always_comb begin
    unique case (reg_addr)
      ADR_CNT: reg_rdata = cnt;
      ADR_CMA: reg_rdata = cmp_a_q;
      ADR_CMB: reg_rdata = cmp_b_q;
      default: reg_rdata = {flags[FLG_CMB], flags[FLG_CMA], flags[FLG_OVF],
                            {PAD_W{1'b0}}, act_q};
    endcase
  end

  // R4: an A match in a counting cycle raises its flag
  a_r4_flag_a: assert property (@(posedge clk) disable iff (!rst_i)
    (cnt_en && cnt == cmp_a_q) |=> flags[FLG_CMA]);

  // R5: a B match in a counting cycle raises its flag
  a_r5_flag_b: assert property (@(posedge clk) disable iff (!rst_i)
    (cnt_en && cnt == cmp_b_q) |=> flags[FLG_CMB]);

  // R3: wrap from all-ones raises rollover flag
  a_r3_flag_ovf: assert property (@(posedge clk) disable iff (!rst_i)
    (cnt_en && !wr_cnt && cnt == {DW{1'b1}}) |=> flags[FLG_OVF]);

  // R8: pin low whenever both action fields are keep
  a_r8_pin_off: assert property (@(posedge clk) disable iff (!rst_i)
    (act_q == '0) |-> !tmr_out);

endmodule

// File: tb/test_tmr8_dual.sv
module test_tmr8_dual;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       cnt_en;
  logic [1:0] reg_addr;
  logic       reg_wr;
  logic       reg_rd;
  logic [7:0] reg_wdata;
  logic [7:0] reg_rdata;
  logic       tmr_out;
  logic       pin_probe;

  always #5 clk = ~clk;

  tmr8_dual i_tmr8_dual (
    .clk       (clk),
    .rst_n     (rst_n),
    .cnt_en    (cnt_en),
    .reg_addr  (reg_addr),
    .reg_wr    (reg_wr),
    .reg_rd    (reg_rd),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .tmr_out   (tmr_out)
  );

  typedef struct {
    bit         is_pin;
    logic [7:0] exp;
    string      tag;
  } item_t;

  item_t q[$];
  int    n_cmp  = 0;
  int    n_fail = 0;

  logic       cap_v = 1'b0;
  logic [7:0] cap_d;
  logic       cap_p;

  always @(posedge clk) begin
    cap_v <= reg_rd | pin_probe;
    cap_d <= reg_rdata;
    cap_p <= tmr_out;
  end

  // monitor: pops expectations as results are captured
  always @(negedge clk) begin
    if (cap_v) begin
      if (q.size() == 0) begin
        n_fail++;
        $display("FAIL monitor: result with no expectation (got %02h)", cap_d);
      end else begin
        item_t it;
        logic [7:0] act;
        it  = q.pop_front();
        act = it.is_pin ? {7'd0, cap_p} : cap_d;
        n_cmp++;
        if (act !== it.exp) begin
          n_fail++;
          $display("FAIL %s: actual %02h expected %02h", it.tag, act, it.exp);
        end
      end
    end
  end

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd_chk(input logic [1:0] a, input logic [7:0] e, input string tag);
    item_t it;
    it.is_pin = 1'b0; it.exp = e; it.tag = tag;
    q.push_back(it);
    reg_addr = a; reg_rd = 1'b1;
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  task automatic pin_chk(input logic e, input string tag);
    item_t it;
    it.is_pin = 1'b1; it.exp = {7'd0, e}; it.tag = tag;
    q.push_back(it);
    pin_probe = 1'b1;
    @(negedge clk);
    pin_probe = 1'b0;
  endtask

  task automatic pulse(input int n);
    cnt_en = 1'b1;
    repeat (n) @(negedge clk);
    cnt_en = 1'b0;
  endtask

  // load counter then run one counting cycle on that value
  task automatic hit_at(input logic [7:0] v);
    wr(2'd0, v);
    pulse(1);
  endtask

  task automatic summary;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_fail);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: run did not finish");
    summary();
  end

  initial begin
    rst_n = 1'b0; cnt_en = 1'b0; reg_addr = 2'd0; reg_wr = 1'b0;
    reg_rd = 1'b0; reg_wdata = 8'd0; pin_probe = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R11 reset state
    rd_chk(2'd0, 8'h00, "R11 counter after reset");
    rd_chk(2'd1, 8'h00, "R11 compare A after reset");
    rd_chk(2'd2, 8'h00, "R11 compare B after reset");
    rd_chk(2'd3, 8'h00, "R11 status after reset");
    pin_chk(1'b0, "R11 pin after reset");

    // R2 register readback
    wr(2'd1, 8'h10); rd_chk(2'd1, 8'h10, "R2 compare A readback");
    wr(2'd2, 8'h20); rd_chk(2'd2, 8'h20, "R2 compare B readback");

    // R1 counting and load
    wr(2'd0, 8'h05); pulse(3);
    rd_chk(2'd0, 8'h08, "R1 three counting cycles");
    pulse(0);
    rd_chk(2'd0, 8'h08, "R1 hold when disabled");

    // R6 drive high, R8 low before first event, R4 flag
    wr(2'd3, 8'h02);
    wr(2'd0, 8'h0F); pulse(1);
    pin_chk(1'b0, "R8 pin low before first match");
    pulse(1);
    pin_chk(1'b1, "R6 action 10 drives high");
    // R9 write 0 without prior read keeps flag
    wr(2'd3, 8'h02);
    rd_chk(2'd3, 8'h42, "R4 match A flag / R9 unarmed write ignored");
    wr(2'd3, 8'h02);
    rd_chk(2'd3, 8'h02, "R9 armed clear");
    wr(2'd3, 8'hF2);
    rd_chk(2'd3, 8'h02, "R9 writing ones sets nothing");

    // R6 other encodings
    wr(2'd3, 8'h01); hit_at(8'h10);
    pin_chk(1'b0, "R6 action 01 drives low");
    wr(2'd3, 8'h03); hit_at(8'h10);
    pin_chk(1'b1, "R6 action 11 inverts (to 1)");
    hit_at(8'h10);
    pin_chk(1'b0, "R6 action 11 inverts (to 0)");
    hit_at(8'h10);
    wr(2'd3, 8'h04); hit_at(8'h10);
    pin_chk(1'b1, "R6 action 00 keeps level");

    // R7 B encodings
    hit_at(8'h20);
    pin_chk(1'b0, "R7 B action 01 drives low");
    wr(2'd3, 8'h08); hit_at(8'h20);
    pin_chk(1'b1, "R7 B action 10 drives high");
    wr(2'd3, 8'h0C); hit_at(8'h20);
    pin_chk(1'b0, "R7 B action 11 inverts");
    rd_chk(2'd3, 8'hCC, "R5 match B flag set");
    wr(2'd3, 8'h0C);
    rd_chk(2'd3, 8'h0C, "R9 both armed flags cleared");

    // R7 coincident events
    wr(2'd1, 8'h30); wr(2'd2, 8'h30);
    wr(2'd3, 8'h02); hit_at(8'h30);
    pin_chk(1'b1, "R7 B keep defers to A");
    wr(2'd3, 8'h06); hit_at(8'h30);
    pin_chk(1'b0, "R7 B clear overrides A set");
    wr(2'd3, 8'h09); hit_at(8'h30);
    pin_chk(1'b1, "R7 B set overrides A clear");
    wr(2'd3, 8'h0D); hit_at(8'h30);
    pin_chk(1'b0, "R7 B invert with A clear inverts once");
    wr(2'd3, 8'h0F); hit_at(8'h30);
    pin_chk(1'b1, "R7 both invert inverts once");

    // R8 gating
    wr(2'd3, 8'h00);
    pin_chk(1'b0, "R8 all-zero actions force pin low");
    wr(2'd3, 8'h02);
    pin_chk(1'b1, "R8 held level returns");

    // R3 rollover
    rd_chk(2'd3, 8'hC2, "R4 R5 flags before rollover");
    wr(2'd3, 8'h02);
    wr(2'd0, 8'hFE); pulse(1);
    rd_chk(2'd3, 8'h02, "R3 no flag at 0xFF");
    pulse(1);
    rd_chk(2'd3, 8'h22, "R3 rollover flag set");
    rd_chk(2'd0, 8'h00, "R3 counter wrapped to 0");
    wr(2'd3, 8'h02);

    // R10 set beats clear
    wr(2'd1, 8'h50); hit_at(8'h50);
    rd_chk(2'd3, 8'h42, "R4 flag A before race");
    wr(2'd0, 8'h50);
    cnt_en = 1'b1; reg_addr = 2'd3; reg_wdata = 8'h02; reg_wr = 1'b1;
    @(negedge clk);
    cnt_en = 1'b0; reg_wr = 1'b0;
    rd_chk(2'd3, 8'h42, "R10 set wins over clearing write");
    wr(2'd3, 8'h02);
    rd_chk(2'd3, 8'h02, "R9 cleared after fresh read");

    repeat (3) @(negedge clk);
    if (q.size() != 0) begin
      n_fail++;
      $display("FAIL monitor: %0d expectations unanswered", q.size());
    end
    summary();
  end

endmodule